// File: doc/BRIEF.md
# Chip-Select Framed 32-Bit Serial Command Receiver

This block is a receive-only slave for three-wire serial control (SPI or MICROWIRE style). While the active-low chip select is held low, it shifts in one data bit on every rising edge of the serial clock, most significant bit first. When chip select returns high, it hands the collected word to the downstream command decoder as one 32-bit value with a single-cycle valid pulse. This happens only if exactly 32 clock edges were counted. Any other count discards the frame.

The serial pins are oversampled in the system clock domain. Each pin passes through a two-flop synchronizer, and edges are found by comparing each synchronized level with its value one cycle earlier. The system clock must run at least four times faster than the serial clock.

The same pins also serve a two-wire bus on the chip. A mode strap enables this receiver only when it indicates three-wire operation. While the strap indicates two-wire mode, every pin activity is ignored.

Top module: `ser_cmd_rx`

## Requirements
- R1: After reset, `word_o` is all zeros and `word_vld_o` is low.
- R2: The first bit shifted in after chip select falls lands in bit 31 of `word_o`, and the last one lands in bit 0.
- R3: A bit is taken only on a rising serial clock edge while chip select is low. Serial clock edges while chip select is high change nothing and produce no pulse.
- R4: When chip select rises after exactly 32 counted edges, `word_vld_o` is high for exactly one cycle and `word_o` carries the new word in that cycle. `word_o` changes at no other time and holds its value until the next commit.
- R5: When chip select rises after any count other than 32 (for example 31 or 33), no pulse is produced and `word_o` keeps its previous value.
- R6: The bit count and the shift register restart at each chip-select fall, so a full frame that follows a discarded short frame is received correctly.
- R7: While `three_wire_en` is 0, no frame is received, no pulse is produced and `word_o` is unchanged. Reception resumes once it is 1.
- R8: A serial clock rise whose synchronized edge falls in the same cycle as the chip-select rise is not counted. So 31 bits plus a coincident edge are discarded, and 32 bits plus a coincident edge are committed.
- R9: `word_vld_o` goes high on the third system clock edge after a chip-select pin rise that is driven midway between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| three_wire_en | input | 1 | Mode strap: 1 selects three-wire reception, 0 leaves the pins to the two-wire bus |
| ser_clk_i | input | 1 | Serial clock pin, asynchronous |
| ser_dat_i | input | 1 | Serial data pin, asynchronous |
| ser_csn_i | input | 1 | Active-low chip select pin, asynchronous |
| word_o | output | WORD_W | Last committed command word |
| word_vld_o | output | 1 | One-cycle pulse marking a new word |

## Verification
The closing chip-select rise and a final serial clock rise can be detected in the same system cycle. In that cycle the frame commit and the bit shift compete for the same counter. The bench provokes this by driving both pins high at the same instant, which gives the two signals identical synchronizer delay. It does this once after 31 bits and once after 32 bits. The scoreboard must see no pulse in the first case, and in the second case a pulse carrying exactly the 32 bits sent before the coincident edge.

// File: rtl/ser_rx_pkg.sv
package ser_rx_pkg;

   // bit positions of the synchronized pin vector
   localparam int unsigned PIN_SCLK = 0;
   localparam int unsigned PIN_DAT  = 1;
   localparam int unsigned PIN_CSN  = 2;
   localparam int unsigned N_PINS   = 3;

   // idle level of the pins: chip select high, clock and data low
   localparam logic [N_PINS-1:0] PINS_IDLE = 3'b100;

   // edge vector layout: sclk rise, csn rise, csn fall
   typedef struct packed {
      logic csn_fall;
      logic csn_rise;
      logic sclk_rise;
   } ser_edges_t;

   localparam logic [2:0] EDGE_SRC_IDLE = 3'b010;

endpackage

// File: rtl/ser_sync_bank.sv
module ser_sync_bank #(
   parameter int unsigned N       = 3,
   parameter int unsigned STAGES  = 2,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d_i,
   output logic [N-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ser_sync_bank: STAGES must be at least 2");
   end
   if (N < 1) begin : g_bad_width
      $error("ser_sync_bank: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
         else        chain <= {chain[STAGES-2:0], d_i[i]};
      end
      assign q_o[i] = chain[STAGES-1];
   end

endmodule

// File: rtl/ser_rise_det.sv
module ser_rise_det #(
   parameter int unsigned N       = 3,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl_i,
   output logic [N-1:0] rise_o
);

   if (N < 1) begin : g_bad_width
      $error("ser_rise_det: N must be at least 1");
   end

   logic [N-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= RST_VAL;
      else        prev <= lvl_i;
   end

   assign rise_o = lvl_i & ~prev;

   for (genvar i = 0; i < N; i++) begin : g_chk
      // R3
      rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rise_o[i] |=> !rise_o[i]);
   end

endmodule

// File: rtl/ser_frame_core.sv
module ser_frame_core #(
   parameter int unsigned WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              csn_lvl_i,
   input  logic              dat_i,
   input  ser_rx_pkg::ser_edges_t edges_i,
   output logic [WORD_W-1:0] word_o,
   output logic              word_vld_o
);

   if (WORD_W < 2) begin : g_bad_width
      $error("ser_frame_core: WORD_W must be at least 2");
   end

   localparam int unsigned CNT_MAX = WORD_W + 1;
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

   logic [CNT_W-1:0]  bit_cnt;
   logic [WORD_W-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt    <= '0;
         shreg      <= '0;
         word_o     <= '0;
         word_vld_o <= 1'b0;
      end else begin
         word_vld_o <= 1'b0;
         if (!en_i) begin
            bit_cnt <= '0;
            shreg   <= '0;
         end else if (edges_i.csn_fall) begin
            bit_cnt <= '0;
            shreg   <= '0;
         end else if (edges_i.csn_rise) begin
            if (bit_cnt == CNT_W'(WORD_W)) begin
               word_o     <= shreg;
               word_vld_o <= 1'b1;
            end
            bit_cnt <= '0;
         end else if (!csn_lvl_i && edges_i.sclk_rise) begin
            shreg <= {shreg[WORD_W-2:0], dat_i};
            if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
         end
      end
   end

   // R4
   vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld_o |=> !word_vld_o);

   // R4
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_o != $past(word_o)) |-> word_vld_o);

   // R7
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !word_vld_o);

   // R5
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(CNT_MAX));

endmodule

// File: rtl/ser_cmd_rx.sv
module ser_cmd_rx #(
   parameter int unsigned WORD_W      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              three_wire_en,
   input  logic              ser_clk_i,
   input  logic              ser_dat_i,
   input  logic              ser_csn_i,
   output logic [WORD_W-1:0] word_o,
   output logic              word_vld_o
);
   import ser_rx_pkg::*;

   logic [N_PINS-1:0] pins_raw;
   logic [N_PINS-1:0] pins_s;
   logic [2:0]        edge_src;
   ser_edges_t        edges;

   always_comb begin
      pins_raw           = '0;
      pins_raw[PIN_SCLK] = ser_clk_i;
      pins_raw[PIN_DAT]  = ser_dat_i;
      pins_raw[PIN_CSN]  = ser_csn_i;
   end

   ser_sync_bank #(
      .N       (N_PINS),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PINS_IDLE)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pins_raw),
      .q_o   (pins_s)
   );

   // a falling chip select is a rising edge of its complement
   assign edge_src = {~pins_s[PIN_CSN], pins_s[PIN_CSN], pins_s[PIN_SCLK]};

   ser_rise_det #(
      .N       (3),
      .RST_VAL (EDGE_SRC_IDLE)
   ) edge_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (edge_src),
      .rise_o (edges)
   );

   ser_frame_core #(
      .WORD_W (WORD_W)
   ) core_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (three_wire_en),
      .csn_lvl_i  (pins_s[PIN_CSN]),
      .dat_i      (pins_s[PIN_DAT]),
      .edges_i    (edges),
      .word_o     (word_o),
      .word_vld_o (word_vld_o)
   );

endmodule

// File: tb/ser_cmd_rx_tb_top.sv
module ser_cmd_rx_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        three_wire_en = 1'b1;
   logic        ser_clk_i = 1'b0;
   logic        ser_dat_i = 1'b0;
   logic        ser_csn_i = 1'b1;
   logic [31:0] word_o;
   logic        word_vld_o;

   always #4 clk = ~clk;

   ser_cmd_rx dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .three_wire_en (three_wire_en),
      .ser_clk_i     (ser_clk_i),
      .ser_dat_i     (ser_dat_i),
      .ser_csn_i     (ser_csn_i),
      .word_o        (word_o),
      .word_vld_o    (word_vld_o)
   );

   int          n_checks = 0;
   int          n_fails  = 0;
   int          pulses   = 0;
   bit          done     = 1'b0;
   logic [31:0] exp_q[$];

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on every valid pulse
   always @(negedge clk) begin
      if (rst_n && word_vld_o) begin
         pulses++;
         if (exp_q.size() == 0) begin
            check(1'b0, "R5 unexpected pulse", word_o, 32'h0);
         end else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            check(word_o == e, "R2/R4 committed word", word_o, e);
         end
      end
   end

   task automatic half_wait();
      repeat (4) @(negedge clk);
   endtask

   task automatic send_bit(input bit d);
      @(negedge clk) ser_dat_i = d;
      half_wait();
      ser_clk_i = 1'b1;
      half_wait();
      ser_clk_i = 1'b0;
   endtask

   task automatic open_frame(input logic [31:0] w, input int nbits);
      @(negedge clk) ser_csn_i = 1'b0;
      repeat (6) @(negedge clk);
      for (int i = 0; i < nbits; i++) send_bit(i < 32 ? w[31-i] : 1'b0);
      half_wait();
   endtask

   task automatic frame(input logic [31:0] w, input int nbits, input bit ok);
      open_frame(w, nbits);
      @(negedge clk);
      if (ok) exp_q.push_back(w);
      ser_csn_i = 1'b1;
      repeat (12) @(negedge clk);
   endtask

   // last serial clock rise driven together with the chip-select rise
   task automatic frame_coinc(input logic [31:0] w, input int nbits, input bit ok);
      open_frame(w, nbits);
      @(negedge clk);
      if (ok) exp_q.push_back(w);
      ser_dat_i = 1'b1;
      ser_clk_i = 1'b1;
      ser_csn_i = 1'b1;
      half_wait();
      ser_clk_i = 1'b0;
      repeat (12) @(negedge clk);
   endtask

   task automatic expect_discard(input logic [31:0] w, input int nbits,
                                 input logic [31:0] hold, input string req);
      int p0;
      p0 = pulses;
      frame(w, nbits, 1'b0);
      check(pulses == p0, req, 32'(pulses - p0), 32'h0);
      check(word_o == hold, req, word_o, hold);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      // R1 reset state
      check(word_o == 32'h0, "R1 word after reset", word_o, 32'h0);
      check(word_vld_o == 1'b0, "R1 valid after reset", 32'(word_vld_o), 32'h0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R2 R4 plain frames
      frame(32'hA5C3_0F96, 32, 1'b1);
      frame(32'h8000_0001, 32, 1'b1);

      // R9 latency from chip-select pin rise
      open_frame(32'h1234_5678, 32);
      @(negedge clk);
      exp_q.push_back(32'h1234_5678);
      ser_csn_i = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      check(word_vld_o == 1'b0, "R9 no pulse before third edge", 32'(word_vld_o), 32'h0);
      @(posedge clk);
      @(negedge clk);
      check(word_vld_o == 1'b1, "R9 pulse on third edge", 32'(word_vld_o), 32'h1);
      @(posedge clk);
      @(negedge clk);
      check(word_vld_o == 1'b0, "R4 pulse lasts one cycle", 32'(word_vld_o), 32'h0);
      repeat (8) @(negedge clk);

      // R5 wrong lengths
      expect_discard(32'hDEAD_BEEF, 31, 32'h1234_5678, "R5 31 bits");
      expect_discard(32'hDEAD_BEEF, 33, 32'h1234_5678, "R5 33 bits");

      // R6 short frame then a full one
      expect_discard(32'hFFFF_FFFF, 10, 32'h1234_5678, "R6 short frame");
      frame(32'h0F0F_1234, 32, 1'b1);

      // R3 clock edges with chip select high
      begin
         int p0;
         p0 = pulses;
         for (int i = 0; i < 40; i++) send_bit(1'b1);
         repeat (12) @(negedge clk);
         check(pulses == p0, "R3 clocks with csn high", 32'(pulses - p0), 32'h0);
         check(word_o == 32'h0F0F_1234, "R3 word unchanged", word_o, 32'h0F0F_1234);
      end

      // R7 strap selects two-wire mode
      three_wire_en = 1'b0;
      repeat (4) @(negedge clk);
      expect_discard(32'hFFFF_0000, 32, 32'h0F0F_1234, "R7 strap off");
      three_wire_en = 1'b1;
      repeat (4) @(negedge clk);
      frame(32'h55AA_33CC, 32, 1'b1);

      // R8 coincident serial clock and chip-select rise
      begin
         int p0;
         p0 = pulses;
         frame_coinc(32'hBAD0_0BAD, 31, 1'b0);
         check(pulses == p0, "R8 31 plus coincident edge", 32'(pulses - p0), 32'h0);
         check(word_o == 32'h55AA_33CC, "R8 word kept", word_o, 32'h55AA_33CC);
      end
      frame_coinc(32'hC001_D00D, 32, 1'b1);
      check(word_o == 32'hC001_D00D, "R8 32 plus coincident edge", word_o, 32'hC001_D00D);

      check(exp_q.size() == 0, "R4 all expected words seen", 32'(exp_q.size()), 32'h0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

endmodule